// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

The block keeps a seconds count that advances once per second while the counter is enabled. The one-second tick comes from a prescaler that divides the input clock by `CYC_PER_SEC`. Software reaches the block over a simple register bus with read strobe, write strobe, word index, write data and read data. Through this bus it can preset the count, program a match value, and set the control bits.

A value written to the load register is held as pending. It replaces the count only at the next one-second update, so the visible count never changes between ticks.

When the count reaches the match value on a tick, a raw alarm flag latches. The flag drives the level interrupt output only when interrupt enable is set and interrupt mask is clear. Software acknowledges the alarm by reading the end-of-interrupt register. A constant version word identifies the block.

Top module: `sec_rtc`

## Requirements
- R1: After reset, the count, match, load and control registers read 0, both status bits read 0, and `irq_o` is low.
- R2: While the enable bit (control bit 2) is 1, the count rises by one every `CYC_PER_SEC` clock cycles. The first step comes `CYC_PER_SEC` cycles after the edge that wrote the enable bit. While the enable bit is 0, the count holds its value.
- R3: A write to the load register (index 2) leaves the count unchanged until the next tick. That tick sets the count to the written value instead of incrementing it. The load register reads back the last value written to it.
- R4: At all-ones, a tick holds the count at all-ones when the wrap bit (control bit 3) is 0, and sets it to 0 when the wrap bit is 1.
- R5: Bit 0 of the raw status register (index 5) becomes 1 on the tick where the new count equals the match register (index 1). This happens whatever the values of the enable and mask bits. Loaded values are included in the comparison.
- R6: A read of the end-of-interrupt register (index 6) clears the raw status bit after that cycle. If a new match arrives in the same cycle, the bit stays set.
- R7: `irq_o` and bit 0 of the masked status register (index 4) equal raw status AND interrupt enable (control bit 0) AND NOT interrupt mask (control bit 1).
- R8: The version register (index 7) reads the `VERSION` parameter. Writes to indices 0, 4, 5, 6 and 7 change no register.
- R9: Read data is valid in the same cycle as `rd_i`. Control register bits above bit 3 read 0, and bits above bit 3 of a control write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register word index (byte offset / 4) |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, combinational |
| irq_o | output | 1 | Level alarm interrupt |

## Verification
The bench sets `CYC_PER_SEC` to 4, so a second lasts four clocks. With this setting every tick edge can be counted exactly, and several seconds fit in a few dozen cycles. `DW` stays at 32. The bench presets the count to values near all-ones through the load register, which makes saturation and rollover reachable in a few ticks. `VERSION` is set to a distinctive non-zero word, so that a read of the version register can be told apart from a read of a cleared register.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  typedef enum logic [2:0] {
    RI_COUNT = 3'd0,
    RI_MATCH = 3'd1,
    RI_LOAD  = 3'd2,
    RI_CTRL  = 3'd3,
    RI_MSTAT = 3'd4,
    RI_RSTAT = 3'd5,
    RI_EOI   = 3'd6,
    RI_VER   = 3'd7
  } reg_idx_e;

  // bit 3 wrap, bit 2 enable, bit 1 mask, bit 0 irq enable
  typedef struct packed {
    logic wrap;
    logic en;
    logic mask;
    logic ie;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
  parameter int unsigned CYC_PER_SEC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  generate
    if (CYC_PER_SEC <= 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_div
      localparam int unsigned PW = $clog2(CYC_PER_SEC);
      localparam logic [PW-1:0] LAST = PW'(CYC_PER_SEC - 1);
      logic [PW-1:0] div_q;

      assign tick_o = en_i && (div_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     div_q <= '0;
        else if (!en_i)  div_q <= '0;
        else if (tick_o) div_q <= '0;
        else             div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sec_rtc_counter.sv
module sec_rtc_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wrap_i,
  input  logic          load_we_i,
  input  logic [DW-1:0] load_val_i,
  input  logic [DW-1:0] match_i,
  output logic [DW-1:0] count_o,
  output logic [DW-1:0] load_q_o,
  output logic          load_pend_o,
  output logic          hit_o
);
  localparam logic [DW-1:0] MAX = {DW{1'b1}};

  logic [DW-1:0] count_q, load_q, count_nxt;
  logic          pend_q;

  always_comb begin
    if (pend_q)              count_nxt = load_q;
    else if (count_q != MAX) count_nxt = count_q + 1'b1;
    else if (wrap_i)         count_nxt = '0;
    else                     count_nxt = MAX;
  end

  assign hit_o = tick_i && (count_nxt == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      load_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (tick_i) count_q <= count_nxt;
      // a write in the tick cycle stays pending for the following tick
      if (load_we_i) begin
        load_q <= load_val_i;
        pend_q <= 1'b1;
      end else if (tick_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign count_o     = count_q;
  assign load_q_o    = load_q;
  assign load_pend_o = pend_q;
endmodule

// File: rtl/sec_rtc_regs.sv
module sec_rtc_regs
  import sec_rtc_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter logic [DW-1:0] VERSION = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] count_i,
  input  logic [DW-1:0] load_q_i,
  input  logic          hit_i,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] match_o,
  output logic          load_we_o,
  output logic          raw_o,
  output logic          eoi_rd_o,
  output logic          irq_o
);
  reg_idx_e      idx;
  ctrl_t         ctrl_q;
  logic [DW-1:0] match_q;
  logic          raw_q;
  logic          masked;

  assign idx       = reg_idx_e'(addr_i);
  assign load_we_o = wr_i && (idx == RI_LOAD);
  assign eoi_rd_o  = rd_i && (idx == RI_EOI);
  assign masked    = raw_q && ctrl_q.ie && !ctrl_q.mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      match_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_i && idx == RI_CTRL)  ctrl_q  <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_i && idx == RI_MATCH) match_q <= wdata_i;
      if (hit_i)         raw_q <= 1'b1;  // new event beats acknowledge
      else if (eoi_rd_o) raw_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      RI_COUNT: rdata_o = count_i;
      RI_MATCH: rdata_o = match_q;
      RI_LOAD:  rdata_o = load_q_i;
      RI_CTRL:  rdata_o = DW'(ctrl_q);
      RI_MSTAT: rdata_o = DW'(masked);
      RI_RSTAT: rdata_o = DW'(raw_q);
      RI_EOI:   rdata_o = '0;
      RI_VER:   rdata_o = VERSION;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign match_o = match_q;
  assign raw_o   = raw_q;
  assign irq_o   = masked;
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int unsigned   DW          = 32,
  parameter int unsigned   CYC_PER_SEC = 8,
  parameter logic [DW-1:0] VERSION     = DW'(32'h0001_0000)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  ctrl_t         ctrl;
  logic          tick, load_we, load_pend, hit, raw, eoi_rd;
  logic [DW-1:0] count, load_q, match;

  sec_rtc_prescaler #(.CYC_PER_SEC(CYC_PER_SEC)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.en),
    .tick_o(tick)
  );

  sec_rtc_counter #(.DW(DW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wrap_i     (ctrl.wrap),
    .load_we_i  (load_we),
    .load_val_i (wdata_i),
    .match_i    (match),
    .count_o    (count),
    .load_q_o   (load_q),
    .load_pend_o(load_pend),
    .hit_o      (hit)
  );

  sec_rtc_regs #(.DW(DW), .VERSION(VERSION)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .count_i  (count),
    .load_q_i (load_q),
    .hit_i    (hit),
    .ctrl_o   (ctrl),
    .match_o  (match),
    .load_we_o(load_we),
    .raw_o    (raw),
    .eoi_rd_o (eoi_rd),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick,
  input logic          load_pend,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] count,
  input logic [DW-1:0] match,
  input logic          en,
  input logic          wrap,
  input logic          ie,
  input logic          mask,
  input logic          raw,
  input logic          eoi_rd,
  input logic          irq_o
);
  localparam logic [DW-1:0] MAX = {DW{1'b1}};

  p_hold_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> count == $past(count));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !load_pend && count != MAX |=> count == $past(count) + 1'b1);

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && load_pend |=> count == $past(load_q));

  p_saturate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !load_pend && count == MAX && !wrap |=> count == MAX);

  p_rollover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !load_pend && count == MAX && wrap |=> count == '0);

  p_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !load_pend && count != MAX && (count + 1'b1) == match |=> raw);

  p_eoi_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_rd && !tick |=> !raw);

  p_gate_ie_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie || mask || !raw |-> !irq_o);
endmodule

bind sec_rtc sec_rtc_checker #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .load_pend(load_pend),
  .load_q   (load_q),
  .count    (count),
  .match    (match),
  .en       (ctrl.en),
  .wrap     (ctrl.wrap),
  .ie       (ctrl.ie),
  .mask     (ctrl.mask),
  .raw      (raw),
  .eoi_rd   (eoi_rd),
  .irq_o    (irq_o)
);

// File: tb/sec_rtc_test.sv
module sec_rtc_test;
  localparam int unsigned DW  = 32;
  localparam int unsigned CPS = 4;
  localparam logic [31:0] VER = 32'hC0DE_0102;

  localparam logic [2:0] A_CNT = 3'd0, A_MAT = 3'd1, A_LD = 3'd2, A_CTL = 3'd3;
  localparam logic [2:0] A_MST = 3'd4, A_RST = 3'd5, A_EOI = 3'd6, A_VER = 3'd7;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rd_i = 1'b0, wr_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int unsigned n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  sec_rtc #(.DW(DW), .CYC_PER_SEC(CPS), .VERSION(VER)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; rd_i = 1'b0; wr_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i);
    #1 rd_i = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    do_reset();
    bus_rd(A_CNT, v); check("R1 count", v, '0);
    bus_rd(A_MAT, v); check("R1 match", v, '0);
    bus_rd(A_LD,  v); check("R1 load", v, '0);
    bus_rd(A_CTL, v); check("R1 ctrl", v, '0);
    bus_rd(A_RST, v); check("R1 raw", v, '0);
    bus_rd(A_MST, v); check("R1 masked", v, '0);
    check("R1 irq", DW'(irq_o), '0);
  endtask

  task automatic t_count();
    logic [DW-1:0] v;
    do_reset();
    edges(20);
    bus_rd(A_CNT, v); check("R2 disabled", v, '0);
    bus_wr(A_CTL, 32'h4);          // E0
    edges(3);                      // E3
    bus_rd(A_CNT, v); check("R2 before first tick", v, 32'd0);
    bus_rd(A_CNT, v); check("R2 first tick", v, 32'd1);
    edges(7);                      // E12
    bus_rd(A_CNT, v); check("R2 three ticks", v, 32'd3);
    bus_wr(A_CTL, 32'h0);
    edges(20);
    bus_rd(A_CNT, v); check("R2 hold when off", v, 32'd3);
  endtask

  task automatic t_load();
    logic [DW-1:0] v;
    do_reset();
    bus_wr(A_CTL, 32'h4);          // E0
    bus_wr(A_LD, 32'd100);         // E1
    bus_rd(A_CNT, v); check("R3 not yet visible", v, 32'd0);
    bus_rd(A_LD,  v); check("R3 readback", v, 32'd100);
    edges(1);                      // E4
    bus_rd(A_CNT, v); check("R3 transferred", v, 32'd100);
    edges(3);                      // E8
    bus_rd(A_CNT, v); check("R3 counts on", v, 32'd101);
  endtask

  task automatic t_alarm();
    logic [DW-1:0] v;
    do_reset();
    bus_wr(A_MAT, 32'd2);
    bus_wr(A_CTL, 32'h5);          // E0
    edges(7);                      // E7
    bus_rd(A_RST, v); check("R5 before match", v, '0);
    @(negedge clk_i); check("R7 irq on match", DW'(irq_o), 32'd1);
    bus_rd(A_RST, v); check("R5 raw set", v, 32'd1);
    bus_rd(A_MST, v); check("R7 masked status", v, 32'd1);
    bus_rd(A_EOI, v);
    bus_rd(A_RST, v); check("R6 raw cleared", v, '0);
    check("R6 irq cleared", DW'(irq_o), '0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    do_reset();
    bus_wr(A_MAT, 32'd1);
    bus_wr(A_CTL, 32'h7);          // E0
    edges(4);                      // E4
    @(negedge clk_i); check("R7 masked irq low", DW'(irq_o), '0);
    bus_rd(A_RST, v); check("R5 raw despite mask", v, 32'd1);
    bus_rd(A_MST, v); check("R7 masked status low", v, '0);
    bus_wr(A_CTL, 32'h5);
    @(negedge clk_i); check("R7 unmask raises irq", DW'(irq_o), 32'd1);
    bus_wr(A_CTL, 32'h4);
    @(negedge clk_i); check("R7 ie off lowers irq", DW'(irq_o), '0);
  endtask

  task automatic t_raw_load();
    logic [DW-1:0] v;
    do_reset();
    bus_wr(A_MAT, 32'h50);
    bus_wr(A_LD,  32'h50);
    bus_wr(A_CTL, 32'h4);          // E0
    edges(4);                      // E4
    bus_rd(A_RST, v); check("R5 match by load, ie off", v, 32'd1);
    check("R7 irq off without ie", DW'(irq_o), '0);
  endtask

  task automatic t_wrap(input bit wrap_en);
    logic [DW-1:0] v;
    do_reset();
    bus_wr(A_LD, 32'hFFFF_FFFE);
    bus_wr(A_CTL, wrap_en ? 32'hC : 32'h4);   // E0
    edges(8);                      // E8
    bus_rd(A_CNT, v); check("R4 reach max", v, 32'hFFFF_FFFF);
    edges(3);                      // E12
    bus_rd(A_CNT, v); check("R4 after max", v, wrap_en ? 32'd0 : 32'hFFFF_FFFF);
    edges(3);                      // E16
    bus_rd(A_CNT, v); check("R4 next second", v, wrap_en ? 32'd1 : 32'hFFFF_FFFF);
  endtask

  task automatic t_ignored();
    logic [DW-1:0] v;
    do_reset();
    bus_wr(A_CNT, 32'h1234);
    bus_wr(A_MST, 32'h1);
    bus_wr(A_RST, 32'h1);
    bus_wr(A_EOI, 32'hFF);
    bus_wr(A_VER, 32'h0);
    bus_rd(A_CNT, v); check("R8 count write ignored", v, '0);
    bus_rd(A_RST, v); check("R8 raw write ignored", v, '0);
    bus_rd(A_VER, v); check("R8 version", v, VER);
    bus_wr(A_CTL, 32'hFFFF_FFF3);
    bus_rd(A_CTL, v); check("R9 ctrl upper bits", v, 32'h3);
    bus_rd(A_MST, v); check("R9 masked idle", v, '0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_load();
    t_alarm();
    t_mask();
    t_raw_load();
    t_wrap(1'b0);
    t_wrap(1'b1);
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule